// File: doc/BRIEF.md
# Serial EEPROM Sequential Reader

This block copies the first part of a 4-wire serial EEPROM into a local byte buffer without software help. A single start pulse launches a sweep. The sweep runs one read transaction per 16-bit word, beginning at word address 0 and counting up by one for each transaction. The block drives the select, serial clock and data-in lines and samples the data-out line. Each word is split into two bytes. The high byte goes to the even buffer location and the low byte to the odd location that follows it.

When the last word is in, the block folds a range of buffered bytes together with XOR. It compares the result with a stored check byte. If the two match, the block presents a 6-byte station address taken from a fixed place in the buffer. If they do not match, it raises an error flag and holds the address output at zero. The serial clock runs at a rate set by the `div` input: every half-period lasts `div`+1 system clock cycles. Any buffered byte can be read at any time through a plain combinational read port.

Top module: `mw_eeprom_sweeper`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `csum_err` and `sta_valid` are 0, `sta_addr` is 0 and every buffer byte reads 0.
- R2: Each transaction raises `ee_cs` while `ee_sk` is low. The first three bits shifted out on `ee_di`, each captured on a rising `ee_sk` edge, are 1, 1, 0.
- R3: After those three bits come ADDR_BITS (6) word-address bits, most significant first. The address is 0 for the first transaction of a sweep and grows by one per transaction, up to WORDS-1.
- R4: Each transaction gives exactly 16 further rising `ee_sk` edges. Data-out is sampled after each falling edge, most significant bit first. The word lands with bits 15:8 at byte 2*w and bits 7:0 at byte 2*w+1, readable on `rd_data` for `rd_addr`.
- R5: Between transactions `ee_cs` drops. At the moment it drops, `ee_sk` and `ee_di` are both 0.
- R6: While busy, every high and low half-period of `ee_sk` inside a transaction lasts exactly `div`+1 clock cycles.
- R7: Let X be the XOR of bytes KEY_OFS (2) through SUM_OFS-1 (16), bytes outside that range excluded. At the end of a sweep, if X equals byte SUM_OFS (17), `sta_valid`=1 and `csum_err`=0. Otherwise `csum_err`=1, `sta_valid`=0 and `sta_addr`=0.
- R8: When valid, `sta_addr` holds bytes STA_OFS (4) through STA_OFS+5, with byte STA_OFS in bits 47:40 and byte STA_OFS+5 in bits 7:0.
- R9: `busy` is 1 from the cycle after an accepted start until the end of the sweep. `done` is a one-cycle pulse in the first cycle with `busy` low. A start while busy is ignored and does not restart the address sequence.
- R10: An accepted start clears `csum_err` and `sta_valid` in the next cycle, and both stay 0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sweep request, taken only while idle |
| div | input | DIV_W | Half-period length minus one, latched at start |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| csum_err | output | 1 | Check byte mismatch |
| sta_valid | output | 1 | Station address is valid |
| sta_addr | output | 48 | Station address, first byte in the top bits |
| rd_addr | input | $clog2(2*WORDS) | Buffer byte index |
| rd_data | output | 8 | Buffer byte at `rd_addr` |

## Verification
The bench places an EEPROM model on the serial lines. The model decodes every command and hands back words taken from a byte image. A transposed byte order or a shift in the wrong direction shows up as wrong buffer contents. A missing low phase between the command and the data would cost a clock edge, and the per-transaction edge count would catch it.

The checksum range is probed at both ends. Changing the byte just below KEY_OFS must leave the sweep valid. Changing byte KEY_OFS or byte SUM_OFS-1 must flag an error. A range off by one at either end would therefore flip one of these results.

A start pulse in the middle of a sweep must not send the address back to zero. If it did, the model's expected-address queue would disagree. The minimum divider setting is exercised, where any half-period cut short or stretched shows up directly.

// File: rtl/mwr_pkg.sv
`timescale 1ns/1ps
package mwr_pkg;

    // Start bit followed by the two-bit read opcode.
    localparam int unsigned OPC_LEN  = 3;
    localparam logic [2:0]  OPC_CODE = 3'b110;

    // Length of the station address in bytes.
    localparam int unsigned STA_LEN  = 6;

    typedef enum logic [3:0] {
        ST_IDLE,  // lines low, waiting for start
        ST_SEL,   // select up, clock low, one half-period
        ST_CLO,   // command bit set up, clock low
        ST_CHI,   // command bit, clock high
        ST_TURN,  // clock low between command and data
        ST_DHI,   // data bit, clock high
        ST_DLO,   // data bit, clock low, sample at the end
        ST_GAP,   // select down between words
        ST_FIN    // one cycle: evaluate check byte
    } seq_st_e;

endpackage

// File: rtl/mwr_tick.sv
`timescale 1ns/1ps
module mwr_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
    } tick_t;

    tick_t s_q, s_d;

    assign tick = run && (s_q.cnt == s_q.lim);

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.lim = div_in;
            s_d.cnt = '0;
        end else if (run) begin
            if (s_q.cnt == s_q.lim) s_d.cnt = '0;
            else                    s_d.cnt = s_q.cnt + 1'b1;
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/mwr_seq.sv
`timescale 1ns/1ps
module mwr_seq
    import mwr_pkg::*;
#(
    parameter int unsigned WORDS     = 16,
    parameter int unsigned ADDR_BITS = 6,
    parameter int unsigned WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 tick,
    input  logic                 ee_do,
    output logic                 busy,
    output logic                 launch,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di,
    output logic                 wr_en,
    output logic [ADDR_BITS-1:0] wr_idx,
    output logic [WORD_BITS-1:0] wr_data,
    output logic                 fin
);

    localparam int unsigned CMD_LEN = OPC_LEN + ADDR_BITS;
    localparam int unsigned BC_W    = $clog2(CMD_LEN + WORD_BITS);
    localparam logic [BC_W-1:0] CMD_LAST = BC_W'(CMD_LEN - 1);
    localparam logic [BC_W-1:0] DAT_LAST = BC_W'(WORD_BITS - 1);
    localparam logic [ADDR_BITS-1:0] LAST_WORD = ADDR_BITS'(WORDS - 1);

    typedef struct packed {
        seq_st_e              st;
        logic [BC_W-1:0]      bitc;
        logic [ADDR_BITS-1:0] word;
        logic [WORD_BITS-2:0] shreg;
    } seq_t;

    seq_t s_q, s_d;

    logic [CMD_LEN-1:0] cmd;
    logic [BC_W-1:0]    cmd_idx;

    assign cmd     = {OPC_CODE, s_q.word};
    assign cmd_idx = CMD_LAST - s_q.bitc;

    // Serial lines are decoded straight from registered state.
    assign busy  = (s_q.st != ST_IDLE);
    assign ee_cs = (s_q.st == ST_SEL) || (s_q.st == ST_CLO) || (s_q.st == ST_CHI) ||
                   (s_q.st == ST_TURN) || (s_q.st == ST_DHI) || (s_q.st == ST_DLO);
    assign ee_sk = (s_q.st == ST_CHI) || (s_q.st == ST_DHI);
    assign ee_di = ((s_q.st == ST_CLO) || (s_q.st == ST_CHI)) && cmd[cmd_idx];

    assign wr_idx  = s_q.word;
    assign wr_data = {s_q.shreg, ee_do};

    always_comb begin
        s_d    = s_q;
        launch = 1'b0;
        wr_en  = 1'b0;
        fin    = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    launch  = 1'b1;
                    s_d.st   = ST_SEL;
                    s_d.word = '0;
                    s_d.bitc = '0;
                end
            end
            ST_SEL: begin
                if (tick) begin
                    s_d.st   = ST_CLO;
                    s_d.bitc = '0;
                end
            end
            ST_CLO: begin
                if (tick) s_d.st = ST_CHI;
            end
            ST_CHI: begin
                if (tick) begin
                    if (s_q.bitc == CMD_LAST) begin
                        s_d.st   = ST_TURN;
                        s_d.bitc = '0;
                    end else begin
                        s_d.st   = ST_CLO;
                        s_d.bitc = s_q.bitc + 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (tick) s_d.st = ST_DHI;
            end
            ST_DHI: begin
                if (tick) s_d.st = ST_DLO;
            end
            ST_DLO: begin
                if (tick) begin
                    s_d.shreg = wr_data[WORD_BITS-2:0];
                    if (s_q.bitc == DAT_LAST) begin
                        wr_en  = 1'b1;
                        s_d.st = ST_GAP;
                    end else begin
                        s_d.st   = ST_DHI;
                        s_d.bitc = s_q.bitc + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (s_q.word == LAST_WORD) begin
                        s_d.st = ST_FIN;
                    end else begin
                        s_d.st   = ST_SEL;
                        s_d.word = s_q.word + 1'b1;
                    end
                end
            end
            ST_FIN: begin
                fin    = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/mwr_store.sv
`timescale 1ns/1ps
module mwr_store
    import mwr_pkg::*;
#(
    parameter int unsigned WORDS     = 16,
    parameter int unsigned ADDR_BITS = 6,
    parameter int unsigned KEY_OFS   = 2,
    parameter int unsigned SUM_OFS   = 17,
    parameter int unsigned STA_OFS   = 4,
    localparam int unsigned BYTES    = 2 * WORDS,
    localparam int unsigned RA_W     = $clog2(BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_idx,
    input  logic [15:0]          wr_data,
    input  logic                 fin,
    input  logic [RA_W-1:0]      rd_addr,
    output logic [7:0]           rd_data,
    output logic                 done,
    output logic                 csum_err,
    output logic                 sta_valid,
    output logic [8*STA_LEN-1:0] sta_addr
);

    localparam int unsigned STA_BITS = 8 * STA_LEN;

    typedef struct packed {
        logic [BYTES-1:0][7:0] mem;
        logic [7:0]            acc;
        logic                  done;
        logic                  err;
        logic                  ok;
    } store_t;

    store_t s_q, s_d;

    function automatic logic in_sum(input int unsigned i);
        return (i >= KEY_OFS) && (i < SUM_OFS);
    endfunction

    always_comb begin
        int unsigned hi_i;
        int unsigned lo_i;
        s_d      = s_q;
        s_d.done = 1'b0;
        hi_i     = 2 * int'(wr_idx);
        lo_i     = hi_i + 1;
        if (clear) begin
            s_d.err = 1'b0;
            s_d.ok  = 1'b0;
            s_d.acc = '0;
        end
        if (wr_en && (hi_i < BYTES)) begin
            s_d.mem[hi_i] = wr_data[15:8];
            s_d.mem[lo_i] = wr_data[7:0];
            s_d.acc = s_q.acc ^ (in_sum(hi_i) ? wr_data[15:8] : 8'h00)
                              ^ (in_sum(lo_i) ? wr_data[7:0]  : 8'h00);
        end
        if (fin) begin
            s_d.done = 1'b1;
            if (s_q.acc == s_q.mem[SUM_OFS]) s_d.ok  = 1'b1;
            else                             s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [STA_BITS-1:0] sta_raw;

    for (genvar k = 0; k < STA_LEN; k++) begin : g_sta
        assign sta_raw[STA_BITS-1-8*k -: 8] = s_q.mem[STA_OFS + k];
    end

    assign sta_addr  = s_q.ok ? sta_raw : '0;
    assign sta_valid = s_q.ok;
    assign csum_err  = s_q.err;
    assign done      = s_q.done;
    assign rd_data   = s_q.mem[rd_addr];

endmodule

// File: rtl/mw_eeprom_sweeper.sv
`timescale 1ns/1ps
module mw_eeprom_sweeper
    import mwr_pkg::*;
#(
    parameter int unsigned WORDS     = 16,
    parameter int unsigned ADDR_BITS = 6,
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned KEY_OFS   = 2,
    parameter int unsigned SUM_OFS   = 17,
    parameter int unsigned STA_OFS   = 4,
    localparam int unsigned RA_W     = $clog2(2 * WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    output logic             ee_cs,
    output logic             ee_sk,
    output logic             ee_di,
    input  logic             ee_do,
    output logic             busy,
    output logic             done,
    output logic             csum_err,
    output logic             sta_valid,
    output logic [47:0]      sta_addr,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [7:0]       rd_data
);

    localparam int unsigned WORD_BITS = 16;

    logic                 launch;
    logic                 tick;
    logic                 wr_en;
    logic [ADDR_BITS-1:0] wr_idx;
    logic [WORD_BITS-1:0] wr_data;
    logic                 fin;

    mwr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .run    (busy),
        .div_in (div),
        .tick   (tick)
    );

    mwr_seq #(
        .WORDS     (WORDS),
        .ADDR_BITS (ADDR_BITS),
        .WORD_BITS (WORD_BITS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .ee_do   (ee_do),
        .busy    (busy),
        .launch  (launch),
        .ee_cs   (ee_cs),
        .ee_sk   (ee_sk),
        .ee_di   (ee_di),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .fin     (fin)
    );

    mwr_store #(
        .WORDS     (WORDS),
        .ADDR_BITS (ADDR_BITS),
        .KEY_OFS   (KEY_OFS),
        .SUM_OFS   (SUM_OFS),
        .STA_OFS   (STA_OFS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .fin       (fin),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .done      (done),
        .csum_err  (csum_err),
        .sta_valid (sta_valid),
        .sta_addr  (sta_addr)
    );

endmodule

// File: rtl/mwr_chk.sv
`timescale 1ns/1ps
module mwr_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div,
    input logic             ee_cs,
    input logic             ee_sk,
    input logic             ee_di,
    input logic             busy,
    input logic             done,
    input logic             csum_err,
    input logic             sta_valid,
    input logic [47:0]      sta_addr
);

    // Cycles that ee_sk has held its present value, saturating.
    logic             sk_prev_q;
    logic [DIV_W:0]   run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_prev_q <= 1'b0;
            run_q     <= '0;
        end else begin
            sk_prev_q <= ee_sk;
            if (ee_sk != sk_prev_q)  run_q <= '0;
            else if (run_q != '1)    run_q <= run_q + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sk && !ee_di));

    p_sel_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_sk);

    p_gap_lines_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> (!ee_sk && !ee_di));

    p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ee_sk != sk_prev_q)) |-> (run_q >= {1'b0, div}));

    p_err_hides_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |-> (!sta_valid && (sta_addr == '0)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_flags_low_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sta_valid && !csum_err));

endmodule

bind mw_eeprom_sweeper mwr_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (div),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di),
    .busy      (busy),
    .done      (done),
    .csum_err  (csum_err),
    .sta_valid (sta_valid),
    .sta_addr  (sta_addr)
);

// File: tb/mw_eeprom_sweeper_bench.sv
`timescale 1ns/1ps
module mw_eeprom_sweeper_bench;

    localparam int WORDS   = 16;
    localparam int BYTES   = 2 * WORDS;
    localparam int KEY_OFS = 2;
    localparam int SUM_OFS = 17;
    localparam int STA_OFS = 4;
    localparam int RA_W    = $clog2(BYTES);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [7:0]      div = 8'd1;
    logic            ee_cs, ee_sk, ee_di;
    logic            ee_do = 1'b0;
    logic            busy, done, csum_err, sta_valid;
    logic [47:0]     sta_addr;
    logic [RA_W-1:0] rd_addr = '0;
    logic [7:0]      rd_data;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cycles = 0;

    logic [7:0] img [BYTES];
    int addr_q [$];

    always #2.5 clk = ~clk;

    mw_eeprom_sweeper u_mw_eeprom_sweeper (
        .clk(clk), .rst_n(rst_n), .start(start), .div(div),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .busy(busy), .done(done), .csum_err(csum_err),
        .sta_valid(sta_valid), .sta_addr(sta_addr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // EEPROM model and address scoreboard (R2, R3, R4)
    int         e = 0;
    logic [8:0] cmd = '0;
    logic [5:0] maddr = '0;

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            if (e < 9) begin
                cmd = {cmd[7:0], ee_di};
                if (e == 8) begin
                    chk(cmd[8:6] == 3'b110, "R2 start+opcode", cmd[8:6], 3'b110);
                    if (addr_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected transaction", cmd[5:0], 0);
                    end else begin
                        int a;
                        a = addr_q.pop_front();
                        chk(cmd[5:0] == 6'(a), "R3 word address", cmd[5:0], a);
                    end
                    maddr = cmd[5:0];
                end
            end else if (e < 25) begin
                logic [15:0] w;
                w = (2 * int'(maddr) + 1 < BYTES) ?
                    {img[2*int'(maddr)], img[2*int'(maddr)+1]} : 16'h0;
                ee_do <= w[15 - (e - 9)];
            end
            e++;
        end
    end

    always @(negedge ee_cs) begin
        chk(e == 25, "R4 rising edges per transaction", e, 25);
        e = 0;
        ee_do <= 1'b0;
    end

    // Line-level monitor sampled mid-cycle (R2, R5, R6)
    int   run = 0;
    logic sk_p = 0, cs_p = 0, low_ok = 0;

    always @(negedge clk) begin
        cycles++;
        if (done) done_cnt++;
        if (!rst_n) begin
            run = 0; sk_p = 0; cs_p = 0; low_ok = 0;
        end else begin
            if (ee_cs && !cs_p)
                chk(!ee_sk, "R2 clock low at select", ee_sk, 0);
            if (!ee_cs && cs_p)
                chk(!ee_sk && !ee_di, "R5 lines low at deselect", {ee_sk, ee_di}, 0);
            if (ee_sk != sk_p) begin
                if (sk_p || low_ok)
                    chk(run == int'(div) + 1, "R6 half-period", run, int'(div) + 1);
                if (!ee_sk && ee_cs) low_ok = 1;
                run = 1;
            end else begin
                run++;
            end
            if (!ee_cs) low_ok = 0;
            sk_p = ee_sk;
            cs_p = ee_cs;
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic void fill_img(input logic [7:0] seed);
        for (int i = 0; i < BYTES; i++) img[i] = 8'(i * 37 + 5) ^ seed;
        img[SUM_OFS] = 8'h00;
        for (int i = KEY_OFS; i < SUM_OFS; i++) img[SUM_OFS] ^= img[i];
    endfunction

    function automatic bit img_ok();
        logic [7:0] x = 8'h00;
        for (int i = KEY_OFS; i < SUM_OFS; i++) x ^= img[i];
        return x == img[SUM_OFS];
    endfunction

    function automatic logic [47:0] img_sta();
        logic [47:0] s = '0;
        for (int k = 0; k < 6; k++) s = {s[39:0], img[STA_OFS + k]};
        return s;
    endfunction

    task automatic sweep(input int dv, input int poke_at, input string tag);
        bit          ok;
        int          n;
        int          d0;
        logic [47:0] exp_sta;
        ok      = img_ok();
        exp_sta = ok ? img_sta() : 48'h0;
        div     = 8'(dv);
        for (int a = 0; a < WORDS; a++) addr_q.push_back(a);
        d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, {"R9 busy after start ", tag}, busy, 1);
        chk(!csum_err && !sta_valid, {"R10 flags cleared ", tag}, {csum_err, sta_valid}, 0);
        n = 0;
        while (!done && n < 60000) begin
            @(negedge clk);
            n++;
            start = (n == poke_at);
        end
        start = 1'b0;
        chk(done == 1'b1, {"R9 done seen ", tag}, done, 1);
        chk(busy == 1'b0, {"R9 busy low with done ", tag}, busy, 0);
        chk(csum_err == !ok, {"R7 csum_err ", tag}, csum_err, !ok);
        chk(sta_valid == ok, {"R7 sta_valid ", tag}, sta_valid, ok);
        chk(sta_addr == exp_sta, {"R8 sta_addr ", tag}, sta_addr, exp_sta);
        @(negedge clk);
        chk(done == 1'b0, {"R9 done one cycle ", tag}, done, 0);
        chk(done_cnt - d0 == 1, {"R9 single done ", tag}, done_cnt - d0, 1);
        chk(addr_q.size() == 0, {"R3 all words fetched ", tag}, addr_q.size(), 0);
        for (int i = 0; i < BYTES; i++) begin
            rd_addr = RA_W'(i);
            #1;
            chk(rd_data == img[i], {"R4 buffer byte ", tag}, rd_data, img[i]);
        end
    endtask

    initial begin
        fill_img(8'h00);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 lines", {ee_cs, ee_sk, ee_di}, 0);
        chk({busy, done, csum_err, sta_valid} == 4'b0, "R1 flags",
            {busy, done, csum_err, sta_valid}, 0);
        chk(sta_addr == 48'h0, "R1 sta_addr", sta_addr, 0);
        chk(rd_data == 8'h00, "R1 buffer", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        sweep(1, 0, "base");
        fill_img(8'h5A);
        sweep(0, 0, "min divider");
        fill_img(8'hC3);
        img[KEY_OFS] ^= 8'h10;
        sweep(3, 500, "key byte corrupt, start while busy");
        fill_img(8'h3C);
        img[KEY_OFS - 1] ^= 8'hFF;
        img[SUM_OFS + 1] ^= 8'h81;
        sweep(2, 0, "bytes outside range");
        fill_img(8'h96);
        img[SUM_OFS - 1] ^= 8'h01;
        sweep(1, 0, "last summed byte corrupt");
        fill_img(8'h00);
        sweep(1, 0, "recovery");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule